// File: doc/BRIEF.md
# SDRAM Bank Timing Tracker

This block sits beside an SDRAM command scheduler and answers one question every cycle: may the command the scheduler is proposing be issued on this clock edge? The scheduler presents an operation (open a row, read, write, or close a row) together with a bank number and, for an open, a row address. The tracker returns a legality flag for each of the four operations as they apply to the addressed bank. When the scheduler actually issues a command, it raises the issue strobe, and the tracker updates its per-bank state.

Each bank keeps an open flag, the row it holds open, and small down-counters for the row-to-column delay, the open-to-open spacing within the bank and the close-to-open recovery. One shared counter enforces the minimum spacing between opens to any two banks, so rows in several banks can be open and in use at once. The minimum intervals are given as parameters in picoseconds together with the clock period. Each is turned into a cycle count at elaboration by rounding the quotient up.

If a command is strobed while it is not legal, no state changes. A violation flag is raised for one cycle on the following clock.

Top module: `sdram_bank_timer`

## Requirements
- R1: Every interval parameter becomes a cycle count of ceil(interval_ps / TCK_PS), with a floor of one cycle. With the defaults (4000 ps clock) this gives row-to-column 3 cycles, same-bank open spacing 14, close recovery 5 and cross-bank open spacing 2.
- R2: `cmd_op` codes are 0 = open row (ACT), 1 = read, 2 = write, 3 = precharge. A read or write is legal only while the addressed bank holds an open row.
- R3: A read or write to a bank becomes legal no earlier than RCD cycles after the edge that issued the ACT to that bank. With an ACT at edge t, it is first legal at edge t+RCD.
- R4: An ACT to a bank that already holds an open row is illegal, whatever row it names. The bank must be precharged first.
- R5: Two ACTs to the same bank must be at least RC cycles apart.
- R6: After a precharge to a bank, an ACT to that bank must wait at least RP cycles.
- R7: ACTs to different banks must be at least RRD cycles apart. Several banks may hold open rows at the same time.
- R8: A precharge is legal only while the addressed bank holds an open row.
- R9: A strobed command that is not legal changes no bank state and sets `violation` high for exactly the next cycle. When the strobe is low, nothing changes and no violation is flagged.
- R10: `open_row` shows the row stored for the addressed bank by its last legal ACT. `bank_open` shows the open flag of every bank, with bit b for bank b.
- R11: While in reset and just after it, every bank is closed, all counters are zero, ACT is legal to every bank, read, write and precharge are not legal, and `violation` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Issue strobe: the presented command is issued on this edge |
| cmd_op | input | 2 | Operation: 0 ACT, 1 read, 2 write, 3 precharge |
| cmd_bank | input | $clog2(NUM_BANKS) | Addressed bank |
| cmd_row | input | ROW_W | Row address, used by ACT |
| ok_act | output | 1 | ACT to the addressed bank is legal now |
| ok_rd | output | 1 | Read to the addressed bank is legal now |
| ok_wr | output | 1 | Write to the addressed bank is legal now |
| ok_pre | output | 1 | Precharge to the addressed bank is legal now |
| open_row | output | ROW_W | Row held by the addressed bank |
| bank_open | output | NUM_BANKS | Open flag of each bank |
| violation | output | 1 | An illegal command was strobed on the previous edge |

## Verification
The legality flags and `open_row` are combinational from registered state and the present inputs. They are therefore sampled in the same cycle the command is driven: inputs change on the falling edge and are read shortly after, before the next rising edge. Bank state moves on the rising edge that takes the strobe. `violation` is a register, so each command's expected violation is checked on the falling edge one cycle after it was driven. The stimulus table places commands at exactly the cycle a counter reaches zero and at the cycle before, with edge numbers counted from the first ACT. This pins each interval's conversion to the cycle. A directed poll counts the cycles from a precharge to the first legal ACT.

// File: rtl/sbt_pkg.sv
package sbt_pkg;

    typedef enum logic [1:0] {
        OP_ACT = 2'd0,
        OP_RD  = 2'd1,
        OP_WR  = 2'd2,
        OP_PRE = 2'd3
    } sbt_op_e;

    // Round an interval up to whole clock cycles, never below one (R1).
    function automatic int unsigned ps_to_cycles(input int unsigned ps, input int unsigned tck_ps);
        int unsigned r;
        r = (ps + tck_ps - 1) / tck_ps;
        if (r == 0) r = 1;
        return r;
    endfunction

    function automatic int unsigned max4(input int unsigned a, b, c, d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/sbt_bank.sv
module sbt_bank #(
    parameter int ROW_W   = 12,
    parameter int CNT_W   = 4,
    parameter int RCD_CYC = 3,
    parameter int RC_CYC  = 14,
    parameter int RP_CYC  = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_i,
    input  logic             pre_i,
    input  logic [ROW_W-1:0] row_i,
    output logic             open_o,
    output logic [ROW_W-1:0] row_o,
    output logic             rcd_ok_o,
    output logic             act_ok_o
);

    localparam logic [CNT_W-1:0] RCD_LD = CNT_W'(RCD_CYC - 1);
    localparam logic [CNT_W-1:0] RC_LD  = CNT_W'(RC_CYC - 1);
    localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(RP_CYC - 1);

    typedef struct packed {
        logic             open;
        logic [ROW_W-1:0] row;
        logic [CNT_W-1:0] rcd;
        logic [CNT_W-1:0] rc;
        logic [CNT_W-1:0] rp;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.rcd = (st_q.rcd != '0) ? st_q.rcd - 1'b1 : '0;
        st_d.rc  = (st_q.rc  != '0) ? st_q.rc  - 1'b1 : '0;
        st_d.rp  = (st_q.rp  != '0) ? st_q.rp  - 1'b1 : '0;
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.row  = row_i;
            st_d.rcd  = RCD_LD;
            st_d.rc   = RC_LD;
        end
        if (pre_i) begin
            st_d.open = 1'b0;
            st_d.rp   = RP_LD;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o   = st_q.open;
    assign row_o    = st_q.row;
    assign rcd_ok_o = (st_q.rcd == '0);
    assign act_ok_o = (st_q.rc == '0) && (st_q.rp == '0);

endmodule

// File: rtl/sbt_spacing.sv
module sbt_spacing #(
    parameter int CNT_W   = 4,
    parameter int RRD_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    output logic ok_o
);

    localparam logic [CNT_W-1:0] RRD_LD = CNT_W'(RRD_CYC - 1);

    logic [CNT_W-1:0] gap_d, gap_q;

    always_comb begin
        gap_d = (gap_q != '0) ? gap_q - 1'b1 : '0;
        if (act_i) gap_d = RRD_LD;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gap_q <= '0;
        else        gap_q <= gap_d;
    end

    assign ok_o = (gap_q == '0);

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
    import sbt_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int ROW_W     = 12,
    parameter int TCK_PS    = 4000,
    parameter int TRCD_PS   = 10000,
    parameter int TRC_PS    = 55000,
    parameter int TRP_PS    = 18000,
    parameter int TRRD_PS   = 6000
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid,
    input  logic [1:0]                   cmd_op,
    input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
    input  logic [ROW_W-1:0]             cmd_row,
    output logic                         ok_act,
    output logic                         ok_rd,
    output logic                         ok_wr,
    output logic                         ok_pre,
    output logic [ROW_W-1:0]             open_row,
    output logic [NUM_BANKS-1:0]         bank_open,
    output logic                         violation
);

    localparam int BA_W    = $clog2(NUM_BANKS);
    localparam int RCD_CYC = ps_to_cycles(TRCD_PS, TCK_PS);
    localparam int RC_CYC  = ps_to_cycles(TRC_PS, TCK_PS);
    localparam int RP_CYC  = ps_to_cycles(TRP_PS, TCK_PS);
    localparam int RRD_CYC = ps_to_cycles(TRRD_PS, TCK_PS);
    localparam int MAX_CYC = max4(RCD_CYC, RC_CYC, RP_CYC, RRD_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    logic [NUM_BANKS-1:0] open_w, rcd_ok_w, act_ok_w, act_go, pre_go;
    logic [ROW_W-1:0]     row_w [NUM_BANKS];
    logic                 rrd_ok, legal, issue, any_act;
    logic                 viol_d, viol_q;

    always_comb begin
        ok_act = !open_w[cmd_bank] && act_ok_w[cmd_bank] && rrd_ok;
        ok_rd  = open_w[cmd_bank] && rcd_ok_w[cmd_bank];
        ok_wr  = open_w[cmd_bank] && rcd_ok_w[cmd_bank];
        ok_pre = open_w[cmd_bank];
        unique case (sbt_op_e'(cmd_op))
            OP_ACT:  legal = ok_act;
            OP_RD:   legal = ok_rd;
            OP_WR:   legal = ok_wr;
            default: legal = ok_pre;
        endcase
        issue   = cmd_valid && legal;
        any_act = issue && (sbt_op_e'(cmd_op) == OP_ACT);
        viol_d  = cmd_valid && !legal;
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        assign act_go[b] = any_act && (cmd_bank == BA_W'(b));
        assign pre_go[b] = issue && (sbt_op_e'(cmd_op) == OP_PRE) && (cmd_bank == BA_W'(b));

        sbt_bank #(
            .ROW_W  (ROW_W),
            .CNT_W  (CNT_W),
            .RCD_CYC(RCD_CYC),
            .RC_CYC (RC_CYC),
            .RP_CYC (RP_CYC)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .act_i   (act_go[b]),
            .pre_i   (pre_go[b]),
            .row_i   (cmd_row),
            .open_o  (open_w[b]),
            .row_o   (row_w[b]),
            .rcd_ok_o(rcd_ok_w[b]),
            .act_ok_o(act_ok_w[b])
        );
    end

    sbt_spacing #(
        .CNT_W  (CNT_W),
        .RRD_CYC(RRD_CYC)
    ) u_spacing (
        .clk  (clk),
        .rst_n(rst_n),
        .act_i(any_act),
        .ok_o (rrd_ok)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= 1'b0;
        else        viol_q <= viol_d;
    end

    assign violation = viol_q;
    assign open_row  = row_w[cmd_bank];
    assign bank_open = open_w;

endmodule

// File: rtl/sbt_checks.sv
module sbt_checks #(
    parameter int NUM_BANKS = 4,
    parameter int BA_W      = 2,
    parameter int RCD_CYC   = 3,
    parameter int RC_CYC    = 14,
    parameter int RP_CYC    = 5,
    parameter int RRD_CYC   = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [1:0]           cmd_op,
    input logic [BA_W-1:0]      cmd_bank,
    input logic                 ok_act,
    input logic                 ok_rd,
    input logic                 ok_wr,
    input logic                 ok_pre,
    input logic [NUM_BANKS-1:0] bank_open,
    input logic                 violation
);

    localparam int CW = $clog2(RCD_CYC + RC_CYC + RP_CYC + RRD_CYC + 2);
    localparam logic [CW-1:0] L_RCD = CW'(RCD_CYC);
    localparam logic [CW-1:0] L_RC  = CW'(RC_CYC);
    localparam logic [CW-1:0] L_RP  = CW'(RP_CYC);
    localparam logic [CW-1:0] L_RRD = CW'(RRD_CYC);

    // Cycles since the last legal ACT / precharge, saturating; a value k means k edges ago.
    logic [CW-1:0] s_act [NUM_BANKS];
    logic [CW-1:0] s_pre [NUM_BANKS];
    logic [CW-1:0] s_any;
    logic          act_now, pre_now;

    assign act_now = cmd_valid && (cmd_op == 2'd0) && ok_act;
    assign pre_now = cmd_valid && (cmd_op == 2'd3) && ok_pre;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_any <= '1;
            for (int b = 0; b < NUM_BANKS; b++) begin
                s_act[b] <= '1;
                s_pre[b] <= '1;
            end
        end else begin
            s_any <= act_now ? CW'(1) : ((s_any != '1) ? s_any + 1'b1 : s_any);
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (act_now && cmd_bank == BA_W'(b)) s_act[b] <= CW'(1);
                else if (s_act[b] != '1)             s_act[b] <= s_act[b] + 1'b1;
                if (pre_now && cmd_bank == BA_W'(b)) s_pre[b] <= CW'(1);
                else if (s_pre[b] != '1)             s_pre[b] <= s_pre[b] + 1'b1;
            end
        end
    end

    assert_rd_rcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_act[cmd_bank] < L_RCD) |-> !ok_rd);
    assert_wr_rcd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_act[cmd_bank] < L_RCD) |-> !ok_wr);
    assert_open_blocks_act_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bank_open[cmd_bank] |-> !ok_act);
    assert_same_bank_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_act[cmd_bank] < L_RC) |-> !ok_act);
    assert_precharge_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_pre[cmd_bank] < L_RP) |-> !ok_act);
    assert_cross_bank_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (s_any < L_RRD) |-> !ok_act);
    assert_closed_no_pre_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_open[cmd_bank] |-> !ok_pre);
    assert_closed_no_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bank_open[cmd_bank] |-> !(ok_rd || ok_wr));
    assert_flag_bad_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd1 && !bank_open[cmd_bank]) |=> violation);
    assert_no_strobe_no_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> !violation);
    assert_violation_keeps_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> $stable(bank_open));

endmodule

bind sdram_bank_timer sbt_checks #(
    .NUM_BANKS(NUM_BANKS),
    .BA_W     (BA_W),
    .RCD_CYC  (RCD_CYC),
    .RC_CYC   (RC_CYC),
    .RP_CYC   (RP_CYC),
    .RRD_CYC  (RRD_CYC)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_op   (cmd_op),
    .cmd_bank (cmd_bank),
    .ok_act   (ok_act),
    .ok_rd    (ok_rd),
    .ok_wr    (ok_wr),
    .ok_pre   (ok_pre),
    .bank_open(bank_open),
    .violation(violation)
);

// File: tb/sim_sdram_bank_timer.sv
`timescale 1ns/1ps
module sim_sdram_bank_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [1:0]  cmd_bank = 2'd0;
    logic [11:0] cmd_row = '0;
    logic        ok_act, ok_rd, ok_wr, ok_pre, violation;
    logic [11:0] open_row;
    logic [3:0]  bank_open;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    sdram_bank_timer u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_row(cmd_row), .ok_act(ok_act), .ok_rd(ok_rd),
        .ok_wr(ok_wr), .ok_pre(ok_pre), .open_row(open_row),
        .bank_open(bank_open), .violation(violation)
    );

    typedef struct packed {
        logic        valid;
        logic [1:0]  op;
        logic [1:0]  bank;
        logic [11:0] row;
        logic        exp_ok;
        logic        exp_viol;
    } vec_t;

    // One row per rising edge; edge numbers count from the first ACT.
    // Expected cycle counts: RCD 3, RC 14, RP 5, RRD 2 (R1).
    localparam int NV = 18;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 2'd0, 12'h0AA, 1'b1, 1'b0}, // 0  ACT b0 from reset            R11
        '{1'b1, 2'd1, 2'd0, 12'h000, 1'b0, 1'b1}, // 1  RD b0 one cycle after ACT     R3
        '{1'b1, 2'd0, 2'd1, 12'h033, 1'b1, 1'b0}, // 2  ACT b1 exactly RRD later      R7
        '{1'b1, 2'd0, 2'd2, 12'h044, 1'b0, 1'b1}, // 3  ACT b2 one cycle after b1     R7
        '{1'b1, 2'd1, 2'd0, 12'h000, 1'b1, 1'b0}, // 4  RD b0 after RCD               R3
        '{1'b1, 2'd2, 2'd1, 12'h000, 1'b1, 1'b0}, // 5  WR b1 exactly RCD later       R3 R1
        '{1'b1, 2'd0, 2'd0, 12'h077, 1'b0, 1'b1}, // 6  ACT b0 while open             R4
        '{1'b1, 2'd3, 2'd0, 12'h000, 1'b1, 1'b0}, // 7  PRE b0                        R8
        '{1'b1, 2'd0, 2'd0, 12'h055, 1'b0, 1'b1}, // 8  ACT b0 during recovery        R6
        '{1'b0, 2'd0, 2'd0, 12'h000, 1'b0, 1'b0}, // 9  poll ACT b0                   R6
        '{1'b0, 2'd0, 2'd0, 12'h000, 1'b0, 1'b0}, // 10                               R6
        '{1'b0, 2'd0, 2'd0, 12'h000, 1'b0, 1'b0}, // 11                               R6
        '{1'b0, 2'd0, 2'd0, 12'h000, 1'b0, 1'b0}, // 12 recovery over, spacing not    R5
        '{1'b0, 2'd0, 2'd0, 12'h000, 1'b0, 1'b0}, // 13 one cycle before RC           R5
        '{1'b1, 2'd0, 2'd0, 12'h155, 1'b1, 1'b0}, // 14 ACT b0 exactly RC later       R5 R1
        '{1'b1, 2'd0, 2'd3, 12'h066, 1'b0, 1'b1}, // 15 ACT b3 too soon               R7
        '{1'b1, 2'd0, 2'd3, 12'h066, 1'b1, 1'b0}, // 16 ACT b3 at RRD                 R7
        '{1'b0, 2'd1, 2'd0, 12'h000, 1'b1, 1'b0}  // 17 RD b0 exactly RCD after 14    R3
    };

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    function automatic logic pick(input logic [1:0] op);
        case (op)
            2'd0:    return ok_act;
            2'd1:    return ok_rd;
            2'd2:    return ok_wr;
            default: return ok_pre;
        endcase
    endfunction

    task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] bank, input logic [11:0] row);
        @(negedge clk);
        cmd_valid = v;
        cmd_op    = op;
        cmd_bank  = bank;
        cmd_row   = row;
        #1;
    endtask

    initial begin
        #(4 * 20000);
        n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic prev_viol;
        int   first;

        // Reset state (R11)
        repeat (3) @(posedge clk);
        drive(1'b0, 2'd0, 2'd2, 12'h000);
        chk("R11 bank_open in reset", 32'(bank_open), 32'h0);
        chk("R11 ok_act in reset", 32'(ok_act), 32'h1);
        chk("R11 ok_rd/ok_pre in reset", 32'({ok_rd, ok_wr, ok_pre}), 32'h0);
        chk("R11 violation in reset", 32'(violation), 32'h0);
        rst_n = 1'b1;

        // Table walk
        prev_viol = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i].valid, VEC[i].op, VEC[i].bank, VEC[i].row);
            chk($sformatf("R3/R5/R6/R7 legality vector %0d", i), 32'(pick(VEC[i].op)), 32'(VEC[i].exp_ok));
            chk($sformatf("R9 violation after vector %0d", i - 1), 32'(violation), 32'(prev_viol));
            prev_viol = VEC[i].exp_viol;
        end

        // R10: rows and open flags after the table
        drive(1'b0, 2'd1, 2'd0, 12'h000);
        chk("R9 violation after last vector", 32'(violation), 32'(prev_viol));
        chk("R10 open_row bank0", 32'(open_row), 32'h155);
        chk("R10 R7 bank_open overlap", 32'(bank_open), 32'hB);

        // R4 R9: illegal ACT on open bank1 keeps its row
        drive(1'b1, 2'd0, 2'd1, 12'h3FF);
        chk("R4 ok_act on open bank1", 32'(ok_act), 32'h0);
        drive(1'b0, 2'd1, 2'd1, 12'h000);
        chk("R9 violation after ACT on open bank", 32'(violation), 32'h1);
        chk("R4 R9 bank1 row unchanged", 32'(open_row), 32'h033);

        // R8 R2: closed bank2
        drive(1'b1, 2'd3, 2'd2, 12'h000);
        chk("R8 ok_pre on closed bank2", 32'(ok_pre), 32'h0);
        chk("R2 ok_rd/ok_wr on closed bank2", 32'({ok_rd, ok_wr}), 32'h0);
        drive(1'b0, 2'd3, 2'd2, 12'h000);
        chk("R8 violation after PRE on closed bank", 32'(violation), 32'h1);
        chk("R9 bank_open unchanged after illegal PRE", 32'(bank_open), 32'hB);
        drive(1'b0, 2'd1, 2'd2, 12'h000);
        chk("R9 no violation without strobe", 32'(violation), 32'h0);

        // R1 R6: count cycles from PRE on bank1 to the first legal ACT
        drive(1'b1, 2'd3, 2'd1, 12'h000);
        chk("R8 ok_pre on open bank1", 32'(ok_pre), 32'h1);
        first = 0;
        for (int k = 1; k <= 7; k++) begin
            drive(1'b0, 2'd0, 2'd1, 12'h000);
            if (ok_act && first == 0) first = k;
        end
        chk("R1 R6 cycles from PRE to legal ACT", 32'(first), 32'd5);

        // R11: reset mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        cmd_bank = 2'd0;
        cmd_op   = 2'd0;
        #1;
        chk("R11 bank_open after reset", 32'(bank_open), 32'h0);
        chk("R11 ok_act after reset", 32'(ok_act), 32'h1);
        rst_n = 1'b1;

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule